// File: doc/BRIEF.md
# I2C Target Sixteen-Line GPIO Expander

This block is an I2C target that gives a bus controller access to sixteen general-purpose I/O lines. The lines are grouped as two byte-wide ports. Each port has four registers: a pad-input view, an output value, a polarity-invert mask and a direction mask. That makes eight registers in all. Address `{group, port}` selects one of them. The group codes are 0 for input, 1 for output, 2 for polarity and 3 for direction. Port 0 owns pins 7:0 and port 1 owns pins 15:8. The resulting indices are 0/1 for input, 2/3 for output, 4/5 for polarity and 6/7 for direction.

The controller addresses the target and writes one command byte, which becomes the register pointer. Any further bytes in that write are stored through the pointer. To read, the controller writes the pointer, issues a repeated START and reads. After every data byte the pointer moves to the other port of the same group, so one two-byte burst covers both ports. The pointer is kept across STOP.

An active-low interrupt tells the controller that an input pin has changed since its port was last read. SCL, SDA and the pads are resampled on the system clock. SDA leaves the block as a pull-low enable for an open-drain pad.

Top module: `i2c_gpio_expander`

## Requirements
- R1: The target acknowledges only the 7-bit address 0b010000s, where s is the `addr_sel` pin, and leaves SDA released for any other address.
- R2: The first data byte after a write-direction address loads the pointer with its low three bits only (for example, 0x0B selects index 3).
- R3: Each later data byte of a write is stored in the pointed register, and after every data byte (written or read) the pointer flips its low bit, staying inside the same group.
- R4: A read returns the register selected by the pointer, so pointer write, repeated START, read fetches a chosen register.
- R5: After reset the output registers are 0xFF, the polarity registers 0x00 and the direction registers 0xFF, so `pad_oe` is all zeros and `pad_out` all ones.
- R6: A direction bit of 0 enables the pad driver (`pad_oe`=1) with the matching output bit on `pad_out`; a bit of 1 disables it.
- R7: An input register reads the resampled pad level XOR its polarity mask, and writes to the input registers leave their read value unchanged.
- R8: The target pulls SDA low in the acknowledge slot of every byte written to it; on reads it sends MSB first and continues only while the controller acknowledges.
- R9: `irq_n` goes low when any direction-input pin differs from its level at the last read of its port's input register, and returns high when that port's input register is read or the pin goes back.
- R10: A STOP returns the bus engine to idle and releases SDA without changing the pointer, so a later read with no pointer write continues from the retained index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the bus |
| sda_i | input | 1 | SDA level from the bus |
| addr_sel | input | 1 | Strap for address bit 0 |
| sda_oe | output | 1 | 1 pulls SDA low |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| irq_n | output | 1 | Active-low change interrupt |

## Verification
The bench builds the block with its defaults: two ports, two resampling stages and address bits 0b010000. Together with a bit time of forty system clocks, these settings let every register index and both straps be reached. They also let the pointer mask and the in-group wrap be observed at pins and on the bus. The repeated-START read path and the interrupt set and clear paths are driven edge by edge by a bus model in the bench.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] GRP_IN  = 2'd0;
  localparam logic [1:0] GRP_OUT = 2'd1;
  localparam logic [1:0] GRP_POL = 2'd2;
  localparam logic [1:0] GRP_DIR = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WR,
    ST_ACK_W,
    ST_RD,
    ST_MACK
  } tgt_state_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target
  import gpx_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic              wr_ptr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_en,
  output logic              sda_oe
);
  logic scl_p, sda_p;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  tgt_state_e state;
  logic [3:0] cnt;
  logic [BYTE_W-1:0] shreg, tx;
  logic rw_q, first_q, nack_q;

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p   <= 1'b1;
      sda_p   <= 1'b1;
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      tx      <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      nack_q  <= 1'b0;
      wr_en   <= 1'b0;
      wr_ptr  <= 1'b0;
      wr_data <= '0;
      rd_en   <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
      wr_en <= 1'b0;
      rd_en <= 1'b0;
      if (start_ev) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (shreg[7:1] == {ADDR_HI, addr_sel}) begin
                state   <= ST_ACK_A;
                sda_oe  <= 1'b1;
                rw_q    <= shreg[0];
                first_q <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK_A: begin
            if (scl_fall) begin
              if (rw_q) begin
                state  <= ST_RD;
                cnt    <= '0;
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                rd_en  <= 1'b1;
              end else begin
                state  <= ST_WR;
                cnt    <= '0;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              wr_en   <= 1'b1;
              wr_ptr  <= first_q;
              wr_data <= shreg;
              first_q <= 1'b0;
              state   <= ST_ACK_W;
              sda_oe  <= 1'b1;
            end
          end
          ST_ACK_W: begin
            if (scl_fall) begin
              state  <= ST_WR;
              cnt    <= '0;
              sda_oe <= 1'b0;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                state  <= ST_MACK;
                sda_oe <= 1'b0;
              end else begin
                cnt    <= cnt + 4'd1;
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                state <= ST_IDLE;
              end else begin
                state  <= ST_RD;
                cnt    <= '0;
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                rd_en  <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int SYNC_STAGES = 2,
  localparam int PINS = NUM_PORTS * BYTE_W,
  localparam int PIDX_W = $clog2(NUM_PORTS),
  localparam int PTR_W = PIDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ptr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [PINS-1:0]   pad_s,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq_n,
  output logic [PTR_W-1:0]  ptr
);
  localparam int PCW = $clog2(SYNC_STAGES + 2);

  logic [1:0] ptr_grp;
  logic [PIDX_W-1:0] ptr_port;
  logic [PIDX_W+2:0] base;
  logic [PINS-1:0] out_all, pol_all, dir_all, in_all;
  logic [NUM_PORTS-1:0] pend;
  logic [PCW-1:0] pcnt;
  logic primed;

  assign ptr_grp  = ptr[PTR_W-1:PIDX_W];
  assign ptr_port = ptr[PIDX_W-1:0];
  assign base     = {ptr_port, 3'b000};
  assign primed   = (pcnt == PCW'(SYNC_STAGES + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_en && wr_ptr) begin
      ptr <= wr_data[PTR_W-1:0];
    end else if (wr_en || rd_en) begin
      ptr <= {ptr_grp, ptr_port + PIDX_W'(1)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else if (!primed) pcnt <= pcnt + PCW'(1);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [BYTE_W-1:0] out_q, pol_q, dir_q, snap_q, pins;
    logic hit;

    assign pins = pad_s[p*BYTE_W +: BYTE_W];
    assign hit  = (ptr_port == PIDX_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= '1;
        pol_q <= '0;
        dir_q <= '1;
      end else if (wr_en && !wr_ptr && hit) begin
        unique case (ptr_grp)
          GRP_OUT: out_q <= wr_data;
          GRP_POL: pol_q <= wr_data;
          GRP_DIR: dir_q <= wr_data;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) snap_q <= '0;
      else if (!primed) snap_q <= pins;
      else if (rd_en && hit && ptr_grp == GRP_IN) snap_q <= pins;
    end

    assign out_all[p*BYTE_W +: BYTE_W] = out_q;
    assign pol_all[p*BYTE_W +: BYTE_W] = pol_q;
    assign dir_all[p*BYTE_W +: BYTE_W] = dir_q;
    assign in_all[p*BYTE_W +: BYTE_W]  = pins ^ pol_q;
    assign pend[p] = |((pins ^ snap_q) & dir_q);
  end

  always_comb begin
    unique case (ptr_grp)
      GRP_IN:  rd_data = in_all[base +: BYTE_W];
      GRP_OUT: rd_data = out_all[base +: BYTE_W];
      GRP_POL: rd_data = pol_all[base +: BYTE_W];
      default: rd_data = dir_all[base +: BYTE_W];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else irq_n <= ~(primed & (|pend));
  end

  assign pad_out = out_all;
  assign pad_oe  = ~dir_all;
endmodule

// File: rtl/i2c_gpio_expander.sv
module i2c_gpio_expander
  import gpx_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI = 6'b010000,
  localparam int PINS = NUM_PORTS * BYTE_W,
  localparam int PTR_W = $clog2(NUM_PORTS) + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            addr_sel,
  output logic            sda_oe,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic            irq_n
);
  logic scl_s, sda_s;
  logic [PINS-1:0] pad_s;
  logic wr_en, wr_ptr, rd_en;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [PTR_W-1:0] ptr;

  gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  gpx_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pad_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_s)
  );

  gpx_i2c_target #(.ADDR_HI(ADDR_HI)) u_target (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .addr_sel(addr_sel), .rd_data(rd_data), .wr_en(wr_en),
    .wr_ptr(wr_ptr), .wr_data(wr_data), .rd_en(rd_en), .sda_oe(sda_oe)
  );

  gpx_regfile #(.NUM_PORTS(NUM_PORTS), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pad_s(pad_s),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_n(irq_n), .ptr(ptr)
  );
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
  parameter int PINS = 16,
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_s,
  input logic             sda_oe,
  input logic             wr_en,
  input logic             rd_en,
  input logic [PTR_W-1:0] ptr,
  input logic [PINS-1:0]  pad_out,
  input logic [PINS-1:0]  pad_oe,
  input logic             irq_n
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else past_ok <= 1'b1;
  end

  a_r6_pins_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pad_out) && $stable(pad_oe)));

  a_r3_ptr_moves_only_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || rd_en) |=> $stable(ptr));

  a_r10_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && $rose(sda_s)) |=> !sda_oe);

  a_r8_sda_moves_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r9_irq_needs_input_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !irq_n) |-> ($past(pad_oe) != '1));
endmodule

bind i2c_gpio_expander gpx_checker #(.PINS(PINS), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .sda_oe(sda_oe),
  .wr_en(wr_en), .rd_en(rd_en), .ptr(ptr), .pad_out(pad_out),
  .pad_oe(pad_oe), .irq_n(irq_n)
);

// File: tb/i2c_gpio_expander_tb_top.sv
module i2c_gpio_expander_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic [15:0] pad_in = '0;
  logic sda_oe, irq_n;
  logic [15:0] pad_out, pad_oe;
  wire sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  i2c_gpio_expander dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(2);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~ack);
  endtask

  function automatic logic [6:0] dev_addr();
    return {6'b010000, addr_sel};
  endfunction

  // Write pointer then n data bytes (n = 0..2); every byte must be ACKed (R8).
  task automatic reg_write(input logic [7:0] p, input int n, input logic [7:0] d0, input logic [7:0] d1);
    logic ack;
    i2c_start();
    send_byte({dev_addr(), 1'b0}, ack); chk("R8 address ack", ack, 1'b1);
    send_byte(p, ack); chk("R8 pointer ack", ack, 1'b1);
    if (n > 0) begin send_byte(d0, ack); chk("R8 data ack", ack, 1'b1); end
    if (n > 1) begin send_byte(d1, ack); chk("R8 data ack", ack, 1'b1); end
    i2c_stop();
  endtask

  task automatic read_tail(input int n, output logic [7:0] d0, output logic [7:0] d1);
    logic ack;
    send_byte({dev_addr(), 1'b1}, ack); chk("R4 read address ack", ack, 1'b1);
    recv_byte(n > 1, d0);
    d1 = 8'h00;
    if (n > 1) recv_byte(1'b0, d1);
    i2c_stop();
  endtask

  task automatic reg_read(input logic [7:0] p, input int n, output logic [7:0] d0, output logic [7:0] d1);
    logic ack;
    i2c_start();
    send_byte({dev_addr(), 1'b0}, ack); chk("R4 address ack", ack, 1'b1);
    send_byte(p, ack); chk("R4 pointer ack", ack, 1'b1);
    i2c_start();
    read_tail(n, d0, d1);
  endtask

  task automatic t_reset();
    logic [7:0] a, b;
    chk("R5 pad_oe after reset", pad_oe, 16'h0000);
    chk("R5 pad_out after reset", pad_out, 16'hFFFF);
    chk("R9 irq_n after reset", irq_n, 1'b1);
    chk("R10 sda released after reset", sda_oe, 1'b0);
    reg_read(8'd2, 2, a, b); chk("R5 output regs", {a, b}, 16'hFFFF);
    reg_read(8'd4, 2, a, b); chk("R5 polarity regs", {a, b}, 16'h0000);
    reg_read(8'd6, 2, a, b); chk("R5 direction regs", {a, b}, 16'hFFFF);
  endtask

  task automatic t_address();
    logic ack;
    i2c_start(); send_byte({7'h21, 1'b0}, ack); i2c_stop();
    chk("R1 nack other address strap0", ack, 1'b0);
    addr_sel = 1'b1;
    i2c_start(); send_byte({7'h20, 1'b0}, ack); i2c_stop();
    chk("R1 nack other address strap1", ack, 1'b0);
    reg_write(8'd2, 1, 8'h12, 8'h00);
    chk("R1 write via strapped address", pad_out, 16'hFF12);
    addr_sel = 1'b0;
    reg_write(8'd2, 1, 8'hFF, 8'h00);
    chk("R1 write via base address", pad_out, 16'hFFFF);
  endtask

  task automatic t_direction();
    logic [7:0] a, b;
    reg_write(8'd6, 2, 8'h0F, 8'hF0);
    reg_write(8'd2, 2, 8'hA5, 8'h3C);
    chk("R6 pad_oe from direction", pad_oe, 16'h0FF0);
    chk("R6 pad_out from output regs", pad_out, 16'h3CA5);
    reg_read(8'd6, 2, a, b);
    chk("R4 read direction port0", a, 8'h0F);
    chk("R3 burst read reaches port1", b, 8'hF0);
  endtask

  task automatic t_mask();
    reg_write(8'h0B, 2, 8'h77, 8'h11);
    chk("R2 masked pointer and R3 wrap", pad_out, 16'h7711);
    reg_write(8'hFE, 1, 8'hFF, 8'h00);
    chk("R2 masked pointer to direction", pad_oe, 16'h0F00);
    reg_write(8'd7, 1, 8'hFF, 8'h00);
    chk("R6 all inputs", pad_oe, 16'h0000);
  endtask

  task automatic t_input();
    logic [7:0] a, b;
    pad_in = 16'h12F0;
    reg_write(8'd4, 2, 8'h0F, 8'h00);
    reg_read(8'd0, 2, a, b);
    chk("R7 input xor polarity", {b, a}, 16'h12FF);
    reg_write(8'd0, 2, 8'h55, 8'hAA);
    reg_read(8'd0, 2, a, b);
    chk("R7 input write ignored", {b, a}, 16'h12FF);
    pad_in = 16'h0000;
    reg_read(8'd0, 2, a, b);
    chk("R7 input follows pads", {b, a}, 16'h000F);
    reg_write(8'd4, 2, 8'h00, 8'h00);
    reg_read(8'd0, 2, a, b);
  endtask

  task automatic t_irq();
    logic [7:0] a, b;
    chk("R9 idle irq", irq_n, 1'b1);
    pad_in[9] = 1'b1; qw();
    chk("R9 irq on port1 change", irq_n, 1'b0);
    reg_read(8'd1, 1, a, b);
    chk("R7 port1 value", a, 8'h02);
    chk("R9 irq cleared by read", irq_n, 1'b1);
    pad_in[0] = 1'b1; qw();
    chk("R9 irq on port0 change", irq_n, 1'b0);
    pad_in[0] = 1'b0; qw();
    chk("R9 irq cleared by return", irq_n, 1'b1);
    reg_write(8'd6, 1, 8'hFE, 8'h00);
    pad_in[0] = 1'b1; qw();
    chk("R9 output pin no irq", irq_n, 1'b1);
    reg_write(8'd6, 1, 8'hFF, 8'h00); qw();
    chk("R9 irq after pin turns input", irq_n, 1'b0);
    reg_read(8'd0, 1, a, b);
    chk("R9 irq cleared by port0 read", irq_n, 1'b1);
  endtask

  task automatic t_stop_ptr();
    logic [7:0] a, b;
    reg_write(8'd4, 2, 8'h0F, 8'h5A);
    reg_write(8'd5, 0, 8'h00, 8'h00);
    i2c_start();
    read_tail(2, a, b);
    chk("R10 pointer kept across stop", a, 8'h5A);
    chk("R3 read wraps within group", b, 8'h0F);
    chk("R8 sda released after nack", sda_oe, 1'b0);
    reg_write(8'd4, 2, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_address();
    t_direction();
    t_mask();
    t_input();
    t_irq();
    t_stop_ptr();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule